// File: doc/BRIEF.md
# Interrupt Routing Crossbar

This block sits between a large population of device interrupt lines and a 160-input processor interrupt controller. Most controller inputs are routable. Each routable input has a 9-bit select field that software writes. The field picks which of 420 device sources drives that input. A few controller inputs are hard-wired to fixed internal sources, and no register can reach them. The output vector is indexed by shared interrupt ID rather than by line number, so controller line k appears at bit k+32 of the output.

Select fields are packed two to a 32-bit word on a simple single-cycle bus. The bus has a write enable, a word address and combinational read data. Each field resets to its own default source. Routing is combinational from the registered selects, so a written select steers its output from the clock edge that stores it. Two external interrupt pins are active low and are inverted before they enter the source vector. One select field is deliberately non-functional: its output never leaves its default source.

Top module: `irq_xbar`

## Requirements
- R1: Controller line k (0..159) drives output bit `ctl_irq[k+32]`, so the output spans IDs 32 to 191.
- R2: A routable line outputs the level of source `sel`. A select of 0, or any select of 420 or above, forces the line to 0. Source 0 is an unconnected source that reads as 0.
- R3: After a synchronous reset, each select field holds its default. Line 4 defaults to 1. Lines 7..130 default to the line number minus 5, except line 100, which defaults to 395. Lines 133..138 and 141..159 default to 0.
- R4: Each routable line owns one field in word `line/2`. An even line uses bits [8:0] and an odd line uses bits [24:16]. Line 7 is an exception and sits in bits [24:16] of word 2. Line 133 is also an exception and sits in bits [24:16] of word 65. A write updates both fields of the addressed word.
- R5: A written select reads back and steers its line from the rising edge that accepts the write. In the cycle the write is presented, the old select still reads back and still routes. Read data is combinational from `reg_addr`.
- R6: Lines 0, 1, 2, 3, 5, 6, 131, 132, 139 and 140 are driven by `fixed_irq` bits 0..9, in that ascending line order. No write changes them, and their field positions read 0.
- R7: The field for line 10 (word 5, bits [8:0]) ignores writes. It always reads 5, and line 10 always routes source 5.
- R8: Word bits outside the two fields read 0. Words with no routable field (for example 0, 1, 3 and 66) read 0. Addresses of 80 and above read 0.
- R9: Source 2 is the inverse of `ext_irq_n[0]` and source 114 is the inverse of `ext_irq_n[1]`. Bits 0, 2 and 114 of `dev_irq` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| dev_irq | input | 420 | Device interrupt sources, active high |
| ext_irq_n | input | 2 | External interrupt pins, active low |
| fixed_irq | input | 10 | Fixed sources for the bypass lines |
| ctl_irq | output | 160 | Controller inputs, indexed [191:32] by interrupt ID |

## Verification
A register write and the use of the same select by the routing path and the readback path can fall in the same cycle. The bench holds a write to the word serving line 12 on the bus and samples before the accepting edge. At that point the old source must still drive `ctl_irq[44]` and the old field must still read back. After the edge, both paths must show the new select. The stimulus table also writes words that mix a routable field with a fixed or non-functional one. Every write is followed by whole-vector comparisons against a bench-side model, under all-ones and random source patterns.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

    localparam int SEL_W     = 9;
    localparam int DATA_W    = 32;
    localparam int HI_LSB    = 16;
    localparam int NUM_SRC   = 420;
    localparam int NUM_LINES = 160;
    localparam int ID_BASE   = 32;
    localparam int NUM_FIXED = 10;
    localparam int NUM_WORDS = NUM_LINES / 2;
    localparam int ADDR_W    = $clog2(NUM_WORDS);

    localparam int EXT_SRC_A = 2;
    localparam int EXT_SRC_B = 114;
    localparam int DEAD_LINE = 10;
    localparam int DEAD_SEL  = 5;
    localparam int ODD_LINE  = 100;
    localparam int ODD_SEL   = 395;
    localparam int LAST_SELF_DEFAULT = 125;

    // slot in fixed_irq for a bypass line, -1 for routable lines
    function automatic int fixed_slot(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            5:       return 4;
            6:       return 5;
            131:     return 6;
            132:     return 7;
            139:     return 8;
            140:     return 9;
            default: return -1;
        endcase
    endfunction

    function automatic bit is_fixed(input int k);
        return fixed_slot(k) >= 0;
    endfunction

    // crossbar instance number serving a routable line
    function automatic int xbar_inst(input int k);
        if (k == 4)        return 1;
        else if (k <= 130) return k - 5;
        else               return k - 7;
    endfunction

    function automatic int default_sel(input int k);
        if (is_fixed(k))       return 0;
        else if (k == ODD_LINE) return ODD_SEL;
        else if (xbar_inst(k) <= LAST_SELF_DEFAULT) return xbar_inst(k);
        else                   return 0;
    endfunction

    function automatic int reg_word(input int k);
        if (k == 7)        return 2;
        else if (k == 133) return 65;
        else               return k / 2;
    endfunction

    function automatic bit reg_hi(input int k);
        if (k == 7 || k == 133) return 1'b1;
        else                    return (k % 2) == 1;
    endfunction

endpackage

// File: rtl/irq_xbar_field.sv
module irq_xbar_field
    import irq_xbar_pkg::*;
#(
    parameter int LINE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel
);

    localparam int              WORD    = reg_word(LINE);
    localparam int              LSB     = reg_hi(LINE) ? HI_LSB : 0;
    localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(default_sel(LINE));

    logic             hit;
    logic [SEL_W-1:0] wr_field;

    assign hit      = wr_en && (wr_addr == ADDR_W'(WORD));
    assign wr_field = wr_data[LSB +: SEL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= RST_SEL;
        end else if (hit) begin
            sel <= wr_field;
        end
    end

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        rst |=> (sel == RST_SEL)); // R3

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        hit |=> (sel == $past(wr_field))); // R5

    AST_OTHER_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(sel)); // R4

endmodule

// File: rtl/irq_xbar_route.sv
module irq_xbar_route
    import irq_xbar_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int SW    = SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src,
    input  logic [SW-1:0]    sel,
    output logic             y
);

    logic in_range;

    assign in_range = (sel != '0) && (int'(sel) < N_SRC);
    assign y        = in_range ? src[sel] : 1'b0;

    AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((sel == '0) || (int'(sel) >= N_SRC)) |-> !y); // R2

endmodule

// File: rtl/irq_xbar_readback.sv
module irq_xbar_readback
    import irq_xbar_pkg::*;
#(
    parameter int N_LINES = NUM_LINES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [N_LINES*SEL_W-1:0] sel_flat,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int TOP_FREE_LSB = HI_LSB + SEL_W;

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_LINES; k++) begin
            if (!is_fixed(k) && (reg_word(k) == int'(rd_addr))) begin
                if (reg_hi(k)) begin
                    rd_data[HI_LSB +: SEL_W] = sel_flat[k*SEL_W +: SEL_W];
                end else begin
                    rd_data[0 +: SEL_W] = sel_flat[k*SEL_W +: SEL_W];
                end
            end
        end
    end

    AST_FREE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[DATA_W-1:TOP_FREE_LSB] == '0) &&
        (rd_data[HI_LSB-1:SEL_W] == '0)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= NUM_WORDS) |-> (rd_data == '0)); // R8

endmodule

// File: rtl/irq_xbar.sv
module irq_xbar
    import irq_xbar_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int N_LINES = NUM_LINES,
    parameter int ID_LO   = ID_BASE,
    parameter int N_FIXED = NUM_FIXED,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [AW-1:0]            reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    input  logic [N_SRC-1:0]         dev_irq,
    input  logic [1:0]               ext_irq_n,
    input  logic [N_FIXED-1:0]       fixed_irq,
    output logic [ID_LO+N_LINES-1:ID_LO] ctl_irq
);

    logic [N_SRC-1:0]         src;
    logic [N_LINES*SEL_W-1:0] sel_flat;

    // source vector: slot 0 unconnected, external pins inverted
    always_comb begin
        src            = dev_irq;
        src[0]         = 1'b0;
        src[EXT_SRC_A] = ~ext_irq_n[0];
        src[EXT_SRC_B] = ~ext_irq_n[1];
    end

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        if (is_fixed(k)) begin : g_fixed
            assign sel_flat[k*SEL_W +: SEL_W] = '0;
            assign ctl_irq[ID_LO+k]           = fixed_irq[fixed_slot(k)];
        end else begin : g_routed
            logic [SEL_W-1:0] sel_k;

            if (k == DEAD_LINE) begin : g_dead
                assign sel_k = SEL_W'(default_sel(k));
            end else begin : g_live
                irq_xbar_field #(
                    .LINE (k)
                ) u_field (
                    .clk     (clk),
                    .rst     (rst),
                    .wr_en   (reg_we),
                    .wr_addr (reg_addr),
                    .wr_data (reg_wdata),
                    .sel     (sel_k)
                );
            end

            assign sel_flat[k*SEL_W +: SEL_W] = sel_k;

            irq_xbar_route #(
                .N_SRC (N_SRC),
                .SW    (SEL_W)
            ) u_route (
                .clk (clk),
                .rst (rst),
                .src (src),
                .sel (sel_k),
                .y   (ctl_irq[ID_LO+k])
            );
        end
    end

    irq_xbar_readback #(
        .N_LINES (N_LINES)
    ) u_readback (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (reg_addr),
        .sel_flat (sel_flat),
        .rd_data  (reg_rdata)
    );

    AST_DEAD_FIELD_ROUTE: assert property (@(posedge clk) disable iff (rst)
        ctl_irq[ID_LO+DEAD_LINE] == src[DEAD_SEL]); // R7

endmodule

// File: tb/irq_xbar_bench.sv
module irq_xbar_bench;
    import irq_xbar_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {word address, write data, expected read-back}
    localparam logic [70:0] VEC [NV] = '{
        {7'd4,   32'hFF2C_FE07, 32'h012C_0007},
        {7'd2,   32'h0072_01A3, 32'h0072_01A3},
        {7'd5,   32'h0000_0021, 32'h0000_0005},
        {7'd50,  32'h01FF_01A4, 32'h01FF_01A4},
        {7'd65,  32'h0002_0001, 32'h0002_0001},
        {7'd66,  32'hFFFF_FFFF, 32'h0000_0000},
        {7'd69,  32'h01FF_0123, 32'h0000_0123},
        {7'd70,  32'h0055_01AA, 32'h0055_0000},
        {7'd0,   32'hFFFF_FFFF, 32'h0000_0000},
        {7'd79,  32'h0001_01A3, 32'h0001_01A3},
        {7'd100, 32'h0123_0045, 32'h0000_0000},
        {7'd3,   32'h01FF_01FF, 32'h0000_0000}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 reg_we = 1'b0;
    logic [ADDR_W-1:0]    reg_addr = '0;
    logic [DATA_W-1:0]    reg_wdata = '0;
    logic [DATA_W-1:0]    reg_rdata;
    logic [NUM_SRC-1:0]   dev_irq = '0;
    logic [1:0]           ext_irq_n = 2'b11;
    logic [NUM_FIXED-1:0] fixed_irq = '0;
    logic [ID_BASE+NUM_LINES-1:ID_BASE] ctl_irq;

    int checks = 0;
    int fails  = 0;
    int m_sel [NUM_LINES];

    irq_xbar u_irq_xbar (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_irq   (dev_irq),
        .ext_irq_n (ext_irq_n),
        .fixed_irq (fixed_irq),
        .ctl_irq   (ctl_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---- bench model, written from the requirements ----
    function automatic int b_slot(input int k);
        int list [NUM_FIXED] = '{0, 1, 2, 3, 5, 6, 131, 132, 139, 140};
        for (int i = 0; i < NUM_FIXED; i++) if (list[i] == k) return i;
        return -1;
    endfunction

    function automatic int b_default(input int k);
        if (b_slot(k) >= 0) return 0;
        if (k == 100) return 395;
        if (k == 4) return 1;
        if (k >= 7 && k <= 130) return k - 5;
        return 0;
    endfunction

    function automatic int b_word(input int k);
        if (k == 7) return 2;
        if (k == 133) return 65;
        return k / 2;
    endfunction

    function automatic bit b_hi(input int k);
        if (k == 7 || k == 133) return 1'b1;
        return k[0];
    endfunction

    function automatic logic [31:0] b_read(input int a);
        logic [31:0] r = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (b_slot(k) < 0 && b_word(k) == a) begin
                if (b_hi(k)) r[24:16] = 9'(m_sel[k]);
                else         r[8:0]   = 9'(m_sel[k]);
            end
        end
        return r;
    endfunction

    function automatic logic [NUM_LINES-1:0] b_route();
        logic [NUM_LINES-1:0] v = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            int s = m_sel[k];
            if (b_slot(k) >= 0)              v[k] = fixed_irq[b_slot(k)];
            else if (s == 0 || s >= NUM_SRC) v[k] = 1'b0;
            else if (s == 2)                 v[k] = ~ext_irq_n[0];
            else if (s == 114)               v[k] = ~ext_irq_n[1];
            else                             v[k] = dev_irq[s];
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NUM_LINES; k++) m_sel[k] = b_default(k);
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        for (int k = 0; k < NUM_LINES; k++) begin
            if (b_slot(k) < 0 && k != 10 && b_word(k) == a)
                m_sel[k] = b_hi(k) ? int'(d[24:16]) : int'(d[8:0]);
        end
    endtask

    // ---- checking ----
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NUM_LINES-1:0] got, input logic [NUM_LINES-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_reads(input string req);
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            logic [31:0] e;
            e = (a < NUM_WORDS) ? b_read(a) : 32'h0;
            @(negedge clk);
            reg_addr = ADDR_W'(a);
            #1;
            chk(reg_rdata == e, req, $sformatf("read word %0d", a),
                NUM_LINES'(reg_rdata), NUM_LINES'(e));
        end
    endtask

    task automatic check_routes(input string req);
        for (int p = 0; p < 4; p++) begin
            logic [NUM_LINES-1:0] got, e;
            @(negedge clk);
            if (p == 0) begin
                dev_irq = '1; fixed_irq = '1; ext_irq_n = 2'b00;
            end else begin
                for (int i = 0; i < NUM_SRC; i++) dev_irq[i] = 1'($urandom);
                fixed_irq = NUM_FIXED'($urandom);
                ext_irq_n = 2'($urandom);
            end
            #1;
            got = ctl_irq;
            e   = b_route();
            chk(got == e, req, $sformatf("routing pattern %0d", p), got, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset defaults and layout: R3 R4 R6 R7 R8
        check_reads("R3");
        check_routes("R3");

        // R1: ID numbering of fixed lines
        @(negedge clk);
        dev_irq = '0; ext_irq_n = 2'b11; fixed_irq = 10'b1;
        #1;
        chk(ctl_irq[32] && $countones(ctl_irq) == 1, "R1", "line 0 at ID 32",
            ctl_irq, 160'b1);
        @(negedge clk);
        fixed_irq = 10'b10_0000_0000;
        #1;
        chk(ctl_irq[172] && $countones(ctl_irq) == 1, "R1", "line 140 at ID 172",
            ctl_irq, 160'b1 << 140);

        // R9: external pin into source 2 via line 7, dev bit 2 ignored
        @(negedge clk);
        fixed_irq = '0; dev_irq = '0; ext_irq_n = 2'b10;
        #1;
        chk(ctl_irq[39] == 1'b1, "R9", "ext pin low", NUM_LINES'(ctl_irq[39]), 160'b1);
        @(negedge clk);
        ext_irq_n = 2'b11; dev_irq[2] = 1'b1;
        #1;
        chk(ctl_irq[39] == 1'b0, "R9", "dev bit 2 ignored", NUM_LINES'(ctl_irq[39]), 160'b0);

        // R5: write presented vs accepted, line 12 (ID 44), word 6 low
        @(negedge clk);
        dev_irq = '0; dev_irq[7] = 1'b1;
        reg_we = 1'b1; reg_addr = 7'd6; reg_wdata = 32'h0000_0028;
        #1;
        chk(ctl_irq[44] == 1'b1, "R5", "old source before edge",
            NUM_LINES'(ctl_irq[44]), 160'b1);
        chk(reg_rdata == 32'h0008_0007, "R5", "old readback before edge",
            NUM_LINES'(reg_rdata), 160'h0008_0007);
        @(negedge clk);
        reg_we = 1'b0;
        model_write(6, 32'h0000_0028);
        #1;
        chk(ctl_irq[44] == 1'b0, "R5", "new source after edge",
            NUM_LINES'(ctl_irq[44]), 160'b0);
        chk(reg_rdata == 32'h0000_0028, "R5", "new readback after edge",
            NUM_LINES'(reg_rdata), 160'h28);

        // table walk: R2 R4 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [6:0]  a;
            logic [31:0] d, e;
            {a, d, e} = VEC[v];
            do_write(int'(a), d);
            reg_addr = a;
            #1;
            chk(reg_rdata == e, "R4", $sformatf("table %0d readback", v),
                NUM_LINES'(reg_rdata), NUM_LINES'(e));
            check_routes("R2");
        end
        check_reads("R6");

        // R3: reset in mid-run restores every default
        do_reset();
        check_reads("R3");
        check_routes("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule